// File: doc/BRIEF.md
# HDLC UI Frame Codec

This block frames byte payloads for a point-to-multipoint serial link using an asynchronous, HDLC-like frame made of unnumbered-information elements only. On the transmit side a payload arrives over a valid/ready byte interface together with a destination station address and a poll/final bit. The block emits the opening flag, the address, the control byte, the payload, a 16-bit check sequence and the closing flag as a byte stream. Every octet between the flags that would look like a flag or an escape is replaced by a two-byte escape sequence.

On the receive side the block hunts for a flag and strips the escaping. It keeps a running check sequence and holds back the last two bytes of each frame as the check sequence. It streams the payload of frames addressed to this station, or to the broadcast address, and ends each such frame with a one-cycle status pulse that marks it good or bad. The poll/final bit is carried both ways so that a master can poll a slave, which then answers only after being polled. The polling policy itself lives above this block.

Top module: `hdlc_ui_codec`

## Requirements
- R1: A transmitted frame is the byte 0x7E, the address taken from tx_addr, the control byte (0x03 with tx_pf low, 0x13 with tx_pf high: bits 1:0 set, poll/final at bit 4), the payload bytes in order, two check bytes, and a closing 0x7E. Each frame carries at least one payload byte, and the byte presented with tx_last is its last.
- R2: The check sequence is the CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, run over the address, control and payload. It is complemented and sent low byte first.
- R3: On transmit, any 0x7E or 0x7D between the two flags (address, control, payload or check bytes) is sent as 0x7D followed by the byte XOR 0x20.
- R4: While ser_tx_ready is low the output byte is held. tx_ready is high only in the cycle in which the current payload byte is fully sent, including its escaped second byte.
- R5: On receive, a 0x7D is removed and the next byte is XORed with 0x20. Each payload byte of an accepted frame appears once on rx_data with rx_data_valid, in order, with the frame's address on rx_addr. The receiver holds back the two last bytes as the check sequence.
- R6: When a flag closes a frame of at least four bytes with a CRC residue of 0xF0B8 and a control byte of 0x03 or 0x13, the next cycle has rx_end and rx_good high, with rx_pf equal to control bit 4.
- R7: A frame whose CRC residue is not 0xF0B8 ends with rx_end and rx_bad high.
- R8: A frame of one to three bytes between flags ends with rx_bad. Two adjacent flags produce no output.
- R9: A frame with a correct check sequence but a control byte other than 0x03 or 0x13 ends with rx_bad.
- R10: A frame whose address is neither my_addr nor 0xFF produces neither rx_data_valid nor rx_end.
- R11: A flag that directly follows a 0x7D aborts the frame in progress (rx_end with rx_bad) and opens a new frame.
- R12: rx_good and rx_bad are high only together with rx_end, and never both at once.
- R13: After reset, bytes received before the first flag are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_addr | input | 8 | This station's address for receive filtering |
| tx_addr | input | 8 | Destination address, sampled at frame start |
| tx_pf | input | 1 | Poll/final bit for the frame, sampled at frame start |
| tx_data | input | 8 | Payload byte to send |
| tx_last | input | 1 | Marks the last payload byte |
| tx_valid | input | 1 | Payload byte valid |
| tx_ready | output | 1 | Payload byte consumed this cycle |
| ser_tx_byte | output | 8 | Framed output byte |
| ser_tx_valid | output | 1 | Output byte valid |
| ser_tx_ready | input | 1 | Link accepts the output byte |
| ser_rx_byte | input | 8 | Received line byte |
| ser_rx_valid | input | 1 | Received byte valid |
| rx_addr | output | 8 | Address of the current received frame |
| rx_pf | output | 1 | Poll/final bit of the current received frame |
| rx_data | output | 8 | Received payload byte |
| rx_data_valid | output | 1 | rx_data valid (one cycle) |
| rx_end | output | 1 | End-of-frame pulse |
| rx_good | output | 1 | Frame accepted, with rx_end |
| rx_bad | output | 1 | Frame rejected, with rx_end |

## Verification
The stall and escape properties assume that tx_data, tx_last and tx_valid stay unchanged from the moment tx_valid rises until tx_ready is seen, and that my_addr does not change while frames are received. The bench drives each payload byte from the cycle after a handshake and releases it only after tx_ready. It sets my_addr once after reset, and it stalls the link with a pseudo-random ready pattern so that escape pairs get split across stalls.

// File: rtl/hdlc_ui_pkg.sv
package hdlc_ui_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_B  = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_B   = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_XOR = 8'h20;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_RESID  = 16'hF0B8;

  // Reflected CRC-16 update over one byte, LSB first
  function automatic logic [15:0] crc16_upd(input logic [15:0] c, input logic [BYTE_W-1:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < BYTE_W; k++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction

  function automatic logic needs_escape(input logic [BYTE_W-1:0] b);
    return (b == FLAG_B) || (b == ESC_B);
  endfunction

  function automatic logic [BYTE_W-1:0] ui_ctrl(input logic pf);
    return {3'b000, pf, 4'b0011};
  endfunction

  function automatic logic is_ui_ctrl(input logic [BYTE_W-1:0] c);
    return (c & 8'hEF) == 8'h03;
  endfunction
endpackage

// File: rtl/hdlc_ui_tx.sv
module hdlc_ui_tx
  import hdlc_ui_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_addr,
  input  logic              tx_pf,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_last,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] ser_tx_byte,
  output logic              ser_tx_valid,
  input  logic              ser_tx_ready,
  output logic              esc_ev,
  output logic              in_body
);
  typedef enum logic [2:0] {
    T_IDLE, T_OPEN, T_ADDR, T_CTRL, T_DATA, T_CRCL, T_CRCH, T_CLOSE
  } tx_st_e;

  tx_st_e            st;
  logic [BYTE_W-1:0] addr_q;
  logic              pf_q;
  logic [15:0]       crc;
  logic              esc_done;
  logic [BYTE_W-1:0] raw;
  logic              need_esc;
  logic              fire;
  logic              step;

  always_comb begin
    case (st)
      T_ADDR:  raw = addr_q;
      T_CTRL:  raw = ui_ctrl(pf_q);
      T_DATA:  raw = tx_data;
      T_CRCL:  raw = ~crc[7:0];
      T_CRCH:  raw = ~crc[15:8];
      default: raw = FLAG_B;
    endcase
  end

  assign in_body      = (st == T_ADDR) || (st == T_CTRL) || (st == T_DATA) ||
                        (st == T_CRCL) || (st == T_CRCH);
  assign need_esc     = in_body && needs_escape(raw);
  assign ser_tx_valid = (st != T_IDLE) && ((st != T_DATA) || tx_valid);
  assign ser_tx_byte  = (need_esc && !esc_done) ? ESC_B :
                        (need_esc ? (raw ^ ESC_XOR) : raw);
  assign fire         = ser_tx_valid && ser_tx_ready;
  assign esc_ev       = fire && need_esc && !esc_done;
  assign step         = fire && (!need_esc || esc_done);
  assign tx_ready     = (st == T_DATA) && step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= T_IDLE;
      addr_q   <= '0;
      pf_q     <= 1'b0;
      crc      <= CRC_INIT;
      esc_done <= 1'b0;
    end else begin
      if (esc_ev)    esc_done <= 1'b1;
      else if (step) esc_done <= 1'b0;
      case (st)
        T_IDLE: if (tx_valid) begin
          addr_q <= tx_addr;
          pf_q   <= tx_pf;
          crc    <= CRC_INIT;
          st     <= T_OPEN;
        end
        T_OPEN: if (step) st <= T_ADDR;
        T_ADDR: if (step) begin crc <= crc16_upd(crc, raw); st <= T_CTRL; end
        T_CTRL: if (step) begin crc <= crc16_upd(crc, raw); st <= T_DATA; end
        T_DATA: if (step) begin
          crc <= crc16_upd(crc, raw);
          if (tx_last) st <= T_CRCL;
        end
        T_CRCL:  if (step) st <= T_CRCH;
        T_CRCH:  if (step) st <= T_CLOSE;
        default: if (step) st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_ui_rx.sv
module hdlc_ui_rx
  import hdlc_ui_pkg::*;
#(
  parameter logic [7:0] BCAST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] my_addr,
  input  logic [BYTE_W-1:0] ser_rx_byte,
  input  logic              ser_rx_valid,
  output logic [BYTE_W-1:0] rx_addr,
  output logic              rx_pf,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_data_valid,
  output logic              rx_end,
  output logic              rx_good,
  output logic              rx_bad
);
  localparam int HOLD = 2;            // bytes held back as check sequence
  localparam int CNT_MAX = HOLD + 2;  // address + control + held bytes
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic              in_frame;
  logic              esc;
  logic [CNT_W-1:0]  cnt;
  logic              addr_ok;
  logic [BYTE_W-1:0] ctrl_q;
  logic [BYTE_W-1:0] hold_q [HOLD];
  logic [15:0]       crc;
  logic [BYTE_W-1:0] dbyte;
  logic              is_flag;
  logic              frame_ok;
  logic              report;

  assign is_flag  = ser_rx_byte == FLAG_B;
  assign dbyte    = esc ? (ser_rx_byte ^ ESC_XOR) : ser_rx_byte;
  assign frame_ok = (cnt == CNT_W'(CNT_MAX)) && !esc && (crc == CRC_RESID) && is_ui_ctrl(ctrl_q);
  assign report   = (cnt == '0) ? esc : addr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      esc      <= 1'b0;
      cnt      <= '0;
      addr_ok  <= 1'b0;
      ctrl_q   <= '0;
      crc      <= CRC_INIT;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
      rx_addr  <= '0;
      rx_pf    <= 1'b0;
      rx_data  <= '0;
      rx_data_valid <= 1'b0;
      rx_end   <= 1'b0;
      rx_good  <= 1'b0;
      rx_bad   <= 1'b0;
    end else begin
      rx_data_valid <= 1'b0;
      rx_end   <= 1'b0;
      rx_good  <= 1'b0;
      rx_bad   <= 1'b0;
      if (ser_rx_valid) begin
        if (is_flag) begin
          if (in_frame && report) begin
            rx_end  <= 1'b1;
            rx_good <= frame_ok;
            rx_bad  <= !frame_ok;
          end
          in_frame <= 1'b1;
          esc      <= 1'b0;
          cnt      <= '0;
          crc      <= CRC_INIT;
        end else if (in_frame) begin
          if (ser_rx_byte == ESC_B && !esc) begin
            esc <= 1'b1;
          end else begin
            esc <= 1'b0;
            crc <= crc16_upd(crc, dbyte);
            if (cnt == '0) begin
              rx_addr <= dbyte;
              addr_ok <= (dbyte == my_addr) || (dbyte == BCAST);
            end else if (cnt == CNT_W'(1)) begin
              ctrl_q <= dbyte;
              rx_pf  <= dbyte[4];
            end else begin
              for (int i = HOLD - 1; i > 0; i--) hold_q[i] <= hold_q[i-1];
              hold_q[0] <= dbyte;
              if (cnt == CNT_W'(CNT_MAX) && addr_ok) begin
                rx_data       <= hold_q[HOLD-1];
                rx_data_valid <= 1'b1;
              end
            end
            if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_ui_codec.sv
module hdlc_ui_codec
  import hdlc_ui_pkg::*;
#(
  parameter logic [7:0] BCAST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] my_addr,
  input  logic [7:0] tx_addr,
  input  logic       tx_pf,
  input  logic [7:0] tx_data,
  input  logic       tx_last,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] ser_tx_byte,
  output logic       ser_tx_valid,
  input  logic       ser_tx_ready,
  input  logic [7:0] ser_rx_byte,
  input  logic       ser_rx_valid,
  output logic [7:0] rx_addr,
  output logic       rx_pf,
  output logic [7:0] rx_data,
  output logic       rx_data_valid,
  output logic       rx_end,
  output logic       rx_good,
  output logic       rx_bad
);
  logic tx_esc_ev;   // escape byte leaves this cycle
  logic tx_in_body;  // between opening and closing flag

  hdlc_ui_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .tx_addr(tx_addr), .tx_pf(tx_pf), .tx_data(tx_data),
    .tx_last(tx_last), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .ser_tx_byte(ser_tx_byte), .ser_tx_valid(ser_tx_valid),
    .ser_tx_ready(ser_tx_ready),
    .esc_ev(tx_esc_ev), .in_body(tx_in_body)
  );

  hdlc_ui_rx #(.BCAST(BCAST)) u_rx (
    .clk(clk), .rst_n(rst_n), .my_addr(my_addr),
    .ser_rx_byte(ser_rx_byte), .ser_rx_valid(ser_rx_valid),
    .rx_addr(rx_addr), .rx_pf(rx_pf), .rx_data(rx_data),
    .rx_data_valid(rx_data_valid), .rx_end(rx_end),
    .rx_good(rx_good), .rx_bad(rx_bad)
  );
endmodule

// File: rtl/hdlc_ui_codec_chk.sv
module hdlc_ui_codec_chk #(
  parameter logic [7:0] BCAST = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] my_addr,
  input logic       tx_ready,
  input logic [7:0] ser_tx_byte,
  input logic       ser_tx_valid,
  input logic       ser_tx_ready,
  input logic       tx_esc_ev,
  input logic       tx_in_body,
  input logic [7:0] rx_addr,
  input logic       rx_data_valid,
  input logic       rx_end,
  input logic       rx_good,
  input logic       rx_bad
);
  // R12: status only with the end pulse, exactly one of the two
  p_status_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> (rx_good ^ rx_bad));
  p_status_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_end |-> (!rx_good && !rx_bad));
  // R4: a stalled byte is held
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_tx_valid && !ser_tx_ready) |=> (ser_tx_valid && $stable(ser_tx_byte)));
  // R4: payload consumed only on a link handshake
  p_ready_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (ser_tx_valid && ser_tx_ready));
  // R3: no raw flag inside a frame body
  p_body_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_body && ser_tx_valid) |-> (ser_tx_byte != 8'h7E));
  // R3: the byte after an escape is never itself special
  p_esc_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_esc_ev |=> (ser_tx_valid && ser_tx_byte != 8'h7E && ser_tx_byte != 8'h7D));
  // R10: payload only for this station or broadcast
  p_addr_filter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data_valid |-> ((rx_addr == my_addr) || (rx_addr == BCAST)));
endmodule

bind hdlc_ui_codec hdlc_ui_codec_chk #(.BCAST(BCAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .my_addr(my_addr), .tx_ready(tx_ready),
  .ser_tx_byte(ser_tx_byte), .ser_tx_valid(ser_tx_valid),
  .ser_tx_ready(ser_tx_ready), .tx_esc_ev(tx_esc_ev), .tx_in_body(tx_in_body),
  .rx_addr(rx_addr), .rx_data_valid(rx_data_valid), .rx_end(rx_end),
  .rx_good(rx_good), .rx_bad(rx_bad)
);

// File: tb/hdlc_ui_codec_bench.sv
module hdlc_ui_codec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [7:0] ME = 8'h42;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] my_addr = '0, tx_addr = '0, tx_data = '0, ser_rx_byte = '0;
  logic tx_pf = 1'b0, tx_last = 1'b0, tx_valid = 1'b0, ser_tx_ready = 1'b1, ser_rx_valid = 1'b0;
  logic tx_ready, ser_tx_valid, rx_pf, rx_data_valid, rx_end, rx_good, rx_bad;
  logic [7:0] ser_tx_byte, rx_addr, rx_data;

  int compared = 0, mismatched = 0, cycles = 0, consumed = 0;
  bit stall_on = 1'b0, done = 1'b0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rxd[$];
  int exp_end[$];          // 0 bad, 2 good pf0, 3 good pf1
  logic [7:0] exp_addr = '0;

  hdlc_ui_codec u_hdlc_ui_codec (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  // unstuffed frame content: address, control, payload, check low, check high (R2)
  task automatic mk(input logic [7:0] a, input logic [7:0] c, input logic [7:0] p[$],
                    output logic [7:0] u[$]);
    logic [15:0] s;
    u = {};
    u.push_back(a); u.push_back(c);
    foreach (p[i]) u.push_back(p[i]);
    s = 16'hFFFF;
    foreach (u[i]) s = bcrc(s, u[i]);
    s = ~s;
    u.push_back(s[7:0]); u.push_back(s[15:8]);
  endtask

  task automatic stuff(input logic [7:0] u[$], output logic [7:0] o[$]);
    o = {};
    foreach (u[i]) begin
      if (u[i] == 8'h7E || u[i] == 8'h7D) begin o.push_back(8'h7D); o.push_back(u[i] ^ 8'h20); end
      else o.push_back(u[i]);
    end
  endtask

  // transmit one payload; expected line bytes per R1/R2/R3
  task automatic tx_frame(input logic [7:0] a, input logic pf, input logic [7:0] p[$]);
    logic [7:0] u[$];
    logic [7:0] o[$];
    mk(a, pf ? 8'h13 : 8'h03, p, u);
    stuff(u, o);
    exp_tx.push_back(8'h7E);
    foreach (o[i]) exp_tx.push_back(o[i]);
    exp_tx.push_back(8'h7E);
    consumed = 0;
    tx_addr = a; tx_pf = pf; tx_valid = 1'b1;
    foreach (p[i]) begin
      tx_data = p[i]; tx_last = (i == p.size() - 1);
      forever begin @(negedge clk); if (tx_ready) break; end
      consumed++;
      @(posedge clk); #1;
    end
    tx_valid = 1'b0; tx_last = 1'b0;
    repeat (12) @(posedge clk);
    #1;
    chk(exp_tx.size() == 0, "R1 all frame bytes sent", exp_tx.size(), 0);
    chk(consumed == p.size(), "R4 payload handshakes", consumed, p.size());
  endtask

  task automatic rx_put(input logic [7:0] b, input bit gap);
    ser_rx_byte = b; ser_rx_valid = 1'b1;
    @(posedge clk); #1;
    ser_rx_valid = 1'b0;
    if (gap) begin @(posedge clk); #1; end
  endtask

  // receive model from the requirements R5-R11
  task automatic rx_frame(input logic [7:0] u[$], input bit abort_it);
    logic [7:0] o[$];
    logic [15:0] s;
    int n;
    bit good;
    n = u.size();
    s = 16'hFFFF;
    foreach (u[i]) s = bcrc(s, u[i]);
    if (n > 0) exp_addr = u[0];
    if ((n == 0 && abort_it) || (n > 0 && (u[0] == ME || u[0] == 8'hFF))) begin
      for (int i = 2; i < n - 2; i++) exp_rxd.push_back(u[i]);
      good = (n >= 4) && !abort_it && (s == 16'hF0B8) && ((u[1] & 8'hEF) == 8'h03);
      exp_end.push_back(good ? (2 + int'(u[1][4])) : 0);
    end
    stuff(u, o);
    rx_put(8'h7E, 1'b0);
    foreach (o[i]) rx_put(o[i], (i % 3) == 2);
    if (abort_it) rx_put(8'h7D, 1'b0);
    rx_put(8'h7E, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk(exp_rxd.size() == 0, "R5 payload all delivered", exp_rxd.size(), 0);
    chk(exp_end.size() == 0, "R6 end status delivered", exp_end.size(), 0);
  endtask

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ser_tx_valid && ser_tx_ready) begin
        if (exp_tx.size() == 0) chk(1'b0, "R1 unexpected line byte", ser_tx_byte, 0);
        else begin
          logic [7:0] e;
          e = exp_tx.pop_front();
          chk(ser_tx_byte == e, "R1/R3 line byte", ser_tx_byte, e);
        end
      end
      if (rx_data_valid) begin
        if (exp_rxd.size() == 0) chk(1'b0, "R10 unexpected payload", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rxd.pop_front();
          chk(rx_data == e, "R5 payload byte", rx_data, e);
          chk(rx_addr == exp_addr, "R5 payload address", rx_addr, exp_addr);
        end
      end
      if (rx_end) begin
        if (exp_end.size() == 0) chk(1'b0, "R10 unexpected end", {rx_good, rx_bad}, 0);
        else begin
          int e;
          e = exp_end.pop_front();
          if (e == 0) chk(rx_bad && !rx_good, "R7 bad status", {rx_good, rx_bad}, 1);
          else begin
            chk(rx_good && !rx_bad, "R6 good status", {rx_good, rx_bad}, 2);
            chk(rx_pf == e[0], "R6 poll/final", rx_pf, e[0]);
          end
        end
      end else begin
        chk(!rx_good && !rx_bad, "R12 status without end", {rx_good, rx_bad}, 0);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    ser_tx_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] u[$];
    my_addr = ME;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!ser_tx_valid && !tx_ready, "R4 reset tx idle", {ser_tx_valid, tx_ready}, 0);
    chk(!rx_data_valid && !rx_end, "R12 reset rx idle", {rx_data_valid, rx_end}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R13: noise before the first flag
    rx_put(8'h42, 1'b0); rx_put(8'h03, 1'b0); rx_put(8'h11, 1'b0); rx_put(8'h22, 1'b0);

    // R1 R2: plain frame, full-rate link
    tx_frame(8'h21, 1'b0, '{8'h11, 8'h22, 8'h33});
    // R3 R4: special bytes in address and payload, stalled link
    stall_on = 1'b1;
    tx_frame(8'h7E, 1'b1, '{8'h7E, 8'h7D, 8'h5D, 8'h00, 8'hFF});
    tx_frame(8'h7D, 1'b0, '{8'hA5});
    stall_on = 1'b0;
    tx_frame(8'h05, 1'b1, '{8'h7E});

    // R5 R6: good frame to this station
    mk(ME, 8'h03, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05}, u); rx_frame(u, 1'b0);
    // R5 R6: broadcast, pf set, escaped payload
    mk(8'hFF, 8'h13, '{8'h7E, 8'h7D, 8'h20}, u); rx_frame(u, 1'b0);
    // R10: other station
    mk(8'h55, 8'h03, '{8'h9A, 8'hBC}, u); rx_frame(u, 1'b0);
    // R7: corrupted check byte
    mk(ME, 8'h03, '{8'h10, 8'h20}, u); u[u.size()-1] ^= 8'h01; rx_frame(u, 1'b0);
    // R8: short frame and adjacent flags
    u = '{ME, 8'h03, 8'h11}; rx_frame(u, 1'b0);
    rx_put(8'h7E, 1'b0); rx_put(8'h7E, 1'b0);
    repeat (3) @(posedge clk);
    // R9: wrong control with a valid check sequence
    mk(ME, 8'h00, '{8'h33, 8'h44}, u); rx_frame(u, 1'b0);
    // R11: abort sequence, then a good frame right after
    mk(ME, 8'h03, '{8'h66, 8'h77, 8'h88}, u); rx_frame(u, 1'b1);
    mk(ME, 8'h13, '{8'hC3}, u); rx_frame(u, 1'b0);

    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule